// File: doc/BRIEF.md
# Debug Breakpoint and Status Unit

This block watches each instruction that a simple in-order core presents at its retirement boundary and decides whether a debug exception must be raised. It owns a small debug register file: up to four address comparators, a status word and a control word. Each comparator can watch an instruction address or a data byte range. The unit also times single-step traps and applies the one-instruction shadow that follows a stack-segment load. Delivery of the exception and privilege checking are done elsewhere in the core.

The core presents one instruction per cycle on `ins_vld`. That instruction may also carry a debug-register access (`dr_req`). The unit sorts the instruction into one of four outcomes:

- a fault-like debug exception, in which case the instruction does not complete;
- an invalid-opcode request;
- normal completion;
- normal completion followed by a trap-like debug exception.

Every outcome is registered and appears one clock later.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset the status word reads 0xFFFF0FF0, the control word reads 0x00000400, and `dbg_exc`, `dbg_trap` and `ud_exc` are low.
- R2: Software can change only status bits 3:0, 13 (BD) and 14 (BS). Bits 31:16 and 11:4 always read one, and bits 15 and 12 always read zero. Control bit 10 always reads one, and control bits 11, 12, 14 and 15 always read zero.
- R3: Comparator n is enabled when control bit 2n or 2n+1 is set. When its type field (control bits 17+4n:16+4n) is 00 and `ins_pc` equals its address, the instruction raises a fault-like exception (`dbg_exc`=1, `dbg_trap`=0) and does not complete. The status bits 3:0 then hold the execute matches.
- R4: An instruction presented with `ins_rf` set raises no execute-match exception.
- R5: A data match requires an enabled comparator whose type is 01 (writes only) or 11 (reads or writes); type 10 never matches. Its size field (control bits 19+4n:18+4n) selects a range of 1 (00), 2 (01) or 4 (11 or 10) bytes, aligned down from the comparator address. The access covers 1 (`acc_len`=00), 2 (01) or 4 (11 or 10) bytes from `acc_addr`. The access matches when its bytes overlap that range. The result is a trap-like exception (`dbg_trap`=1) after the instruction completes.
- R6: Every debug exception rewrites status bits 3:0 with the comparators that matched, clearing the others. BS and BD are only ever set by the unit, never cleared by it.
- R7: A completing instruction sets the armed state to its `ins_tf`. The next completing instruction then traps with BS set, so the instruction that raises the flag does not itself trap.
- R8: When a completing instruction has `ins_shadow` set and no deferral is pending, its single-step and data traps are held back. They are merged into the next completing instruction's traps. That next instruction's own shadow is not honoured, so the shadow does not chain.
- R9: With control bit 13 (GD) set, any register access raises a fault-like exception instead of the access. The exception sets BD (status bit 13) and clears GD. A pending shadow deferral does not hold it back.
- R10: Register index 0-3 selects a comparator, 6 the status word and 7 the control word. With `de_mode`=0, index 4 acts as 6 and index 5 as 7. With `de_mode`=1, access to 4 or 5 raises `ud_exc` and changes nothing.
- R11: The outcomes have a fixed priority: an execute match first, then a general-detect fault, then invalid-opcode. A faulting instruction performs no access and changes neither the armed single-step state nor the pending deferral.
- R12: When step and data conditions coincide on one instruction, a single exception is raised and it updates BS together with bits 3:0.
- R13: A read returns the register value from before that instruction's update, on `dr_rdata` one clock later. A status write made by a trapping instruction is applied first, and the trap bits are set on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_vld | input | 1 | An instruction is presented this cycle |
| ins_pc | input | AW | Instruction address |
| ins_rf | input | 1 | Resume flag: suppress execute matches |
| ins_tf | input | 1 | Trap-flag value left by this instruction |
| ins_shadow | input | 1 | Instruction loads the stack segment |
| acc_vld | input | 1 | Instruction makes a data access |
| acc_wr | input | 1 | Data access is a write |
| acc_addr | input | AW | Data access start address |
| acc_len | input | 2 | Data access size code |
| dr_req | input | 1 | Instruction accesses a debug register |
| dr_wr | input | 1 | Register access is a write |
| dr_idx | input | 3 | Register index |
| dr_wdata | input | 32 | Register write data |
| de_mode | input | 1 | Debug-extensions mode |
| dbg_exc | output | 1 | Debug exception request |
| dbg_trap | output | 1 | Request is trap-like (1) or fault-like (0) |
| ud_exc | output | 1 | Invalid-opcode request |
| dr_rdata | output | 32 | Register read data |

## Verification
Every result of this block appears exactly one clock after the rising edge that samples the instruction. That holds for the exception and trap flags, the invalid-opcode request and read data alike. The status and control effects of an instruction become visible to the next instruction's read. The bench drives each instruction on a falling edge, and its behavioural model updates on the rising edge. Outputs are compared at the following falling edge, so every comparison lands on the cycle in which the result is due. Deferred traps (R8) and the one-instruction single-step delay (R7) are checked by counting instructions, not cycles, with idle cycles placed between instructions.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   localparam int unsigned REG_W      = 32;
   localparam logic [31:0] STAT_RST   = 32'hFFFF_0FF0;
   localparam logic [31:0] STAT_WMASK = 32'h0000_600F;
   localparam logic [31:0] CTRL_RST   = 32'h0000_0400;
   localparam logic [31:0] CTRL_WMASK = 32'hFFFF_23FF;
   localparam int unsigned STAT_BD    = 13;
   localparam int unsigned STAT_BS    = 14;
   localparam int unsigned CTRL_GD    = 13;
   localparam logic [2:0]  IDX_STAT   = 3'd6;
   localparam logic [2:0]  IDX_CTRL   = 3'd7;

   typedef enum logic [1:0] {
      KIND_EXEC = 2'b00,
      KIND_WR   = 2'b01,
      KIND_IO   = 2'b10,
      KIND_RDWR = 2'b11
   } match_kind_e;

   typedef enum logic [2:0] {
      OUT_IDLE,
      OUT_XFAULT,
      OUT_GDFAULT,
      OUT_UD,
      OUT_DONE
   } outcome_e;

   // size code -> byte span minus one
   function automatic logic [1:0] span_of(input logic [1:0] code);
      case (code)
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
   import dbg_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          en,
   input  logic [1:0]    kind,
   input  logic [1:0]    size,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] pc,
   input  logic          acc_vld,
   input  logic          acc_wr,
   input  logic [AW-1:0] acc_addr,
   input  logic [1:0]    acc_len,
   output logic          x_hit,
   output logic          d_hit
);
   localparam int unsigned EW = AW + 1;

   logic [1:0]    c_span, a_span;
   logic [AW-1:0] c_mask;
   logic [EW-1:0] c_lo, c_hi, a_lo, a_hi;
   logic          dir_ok, overlap;

   always_comb begin
      c_span  = span_of(size);
      a_span  = span_of(acc_len);
      c_mask  = {{(AW-2){1'b0}}, c_span};
      c_lo    = {1'b0, base & ~c_mask};
      c_hi    = c_lo + {{(EW-2){1'b0}}, c_span};
      a_lo    = {1'b0, acc_addr};
      a_hi    = a_lo + {{(EW-2){1'b0}}, a_span};
      overlap = (a_lo <= c_hi) && (c_lo <= a_hi);
      dir_ok  = (match_kind_e'(kind) == KIND_RDWR) ||
                ((match_kind_e'(kind) == KIND_WR) && acc_wr);
      x_hit   = en && (match_kind_e'(kind) == KIND_EXEC) && (pc == base);
      d_hit   = en && acc_vld && dir_ok && overlap;
   end
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
   import dbg_pkg::*;
#(
   parameter int unsigned AW   = 32,
   parameter int unsigned NCMP = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [2:0]               sel,
   input  logic [REG_W-1:0]         wdata,
   input  logic                     exc_upd,
   input  logic [NCMP-1:0]          exc_hits,
   input  logic                     set_bs,
   input  logic                     set_bd,
   input  logic                     clr_gd,
   output logic [NCMP-1:0][AW-1:0]  cmp_addr,
   output logic [REG_W-1:0]         ctrl,
   output logic [REG_W-1:0]         rdata
);
   logic [REG_W-1:0] stat_q, stat_d, ctrl_q, ctrl_d, rd_mux, rdata_q;
   logic [3:0]       hits_w;

   for (genvar n = 0; n < NCMP; n++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cmp_addr[n] <= '0;
         else if (wr_en && sel == 3'(n))    cmp_addr[n] <= wdata[AW-1:0];
      end
   end

   always_comb begin
      hits_w = '0;
      hits_w[NCMP-1:0] = exc_hits;
      stat_d = stat_q;
      if (wr_en && sel == IDX_STAT)
         stat_d = (wdata & STAT_WMASK) | (STAT_RST & ~STAT_WMASK);
      if (exc_upd) begin
         stat_d[3:0] = hits_w;
         if (set_bs) stat_d[STAT_BS] = 1'b1;
         if (set_bd) stat_d[STAT_BD] = 1'b1;
      end
      ctrl_d = ctrl_q;
      if (wr_en && sel == IDX_CTRL)
         ctrl_d = (wdata & CTRL_WMASK) | CTRL_RST;
      if (clr_gd) ctrl_d[CTRL_GD] = 1'b0;
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         IDX_STAT: rd_mux = stat_q;
         IDX_CTRL: rd_mux = ctrl_q;
         default:
            for (int n = 0; n < NCMP; n++)
               if (sel == 3'(n)) rd_mux = REG_W'(cmp_addr[n]);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= STAT_RST;
         ctrl_q  <= CTRL_RST;
         rdata_q <= '0;
      end else begin
         stat_q <= stat_d;
         ctrl_q <= ctrl_d;
         if (rd_en) rdata_q <= rd_mux;
      end
   end

   assign ctrl  = ctrl_q;
   assign rdata = rdata_q;

   // R9
   gd_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_bd |=> (!ctrl_q[CTRL_GD] && stat_q[STAT_BD]));

   // R6
   bs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_q[STAT_BS]) && !$past(wr_en && sel == IDX_STAT)) |-> stat_q[STAT_BS]);
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
   import dbg_pkg::*;
#(
   parameter int unsigned NCMP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_vld,
   input  logic             ins_rf,
   input  logic             ins_tf,
   input  logic             ins_shadow,
   input  logic             dr_req,
   input  logic             dr_wr,
   input  logic [2:0]       dr_idx,
   input  logic             de_mode,
   input  logic             gd_on,
   input  logic [NCMP-1:0]  x_hits,
   input  logic [NCMP-1:0]  d_hits,
   output logic             wr_en,
   output logic             rd_en,
   output logic [2:0]       sel,
   output logic             exc_upd,
   output logic [NCMP-1:0]  exc_hits,
   output logic             set_bs,
   output logic             set_bd,
   output logic             clr_gd,
   output logic             dbg_exc,
   output logic             dbg_trap,
   output logic             ud_exc
);
   outcome_e        outc;
   logic            is_alias, done, shadow_eff, trap_now;
   logic            tf_armed, pend_vld, pend_bs;
   logic [NCMP-1:0] pend_hits, tot_hits;
   logic            tot_bs;
   logic            exc_q, trap_q, ud_q;

   always_comb begin
      is_alias = (dr_idx[2:1] == 2'b10);
      if (!ins_vld)                           outc = OUT_IDLE;
      else if ((|x_hits) && !ins_rf)          outc = OUT_XFAULT;
      else if (dr_req && gd_on)               outc = OUT_GDFAULT;
      else if (dr_req && de_mode && is_alias) outc = OUT_UD;
      else                                    outc = OUT_DONE;
      done       = (outc == OUT_DONE);
      shadow_eff = ins_shadow && !pend_vld;
      tot_hits   = d_hits | pend_hits;
      tot_bs     = tf_armed | pend_bs;
      trap_now   = done && !shadow_eff && ((|tot_hits) || tot_bs);
      exc_upd    = (outc == OUT_XFAULT) || (outc == OUT_GDFAULT) || trap_now;
      case (outc)
         OUT_XFAULT:  exc_hits = x_hits;
         OUT_GDFAULT: exc_hits = '0;
         default:     exc_hits = tot_hits;
      endcase
      set_bs = trap_now && tot_bs;
      set_bd = (outc == OUT_GDFAULT);
      clr_gd = (outc == OUT_GDFAULT);
      wr_en  = done && dr_req && dr_wr;
      rd_en  = done && dr_req && !dr_wr;
      sel    = (!de_mode && is_alias) ? {2'b11, dr_idx[0]} : dr_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tf_armed  <= 1'b0;
         pend_vld  <= 1'b0;
         pend_bs   <= 1'b0;
         pend_hits <= '0;
         exc_q     <= 1'b0;
         trap_q    <= 1'b0;
         ud_q      <= 1'b0;
      end else begin
         exc_q  <= exc_upd;
         trap_q <= trap_now;
         ud_q   <= (outc == OUT_UD);
         if (done) begin
            tf_armed <= ins_tf;
            if (shadow_eff) begin
               pend_vld  <= 1'b1;
               pend_hits <= d_hits;
               pend_bs   <= tf_armed;
            end else begin
               pend_vld  <= 1'b0;
               pend_hits <= '0;
               pend_bs   <= 1'b0;
            end
         end
      end
   end

   assign dbg_exc  = exc_q;
   assign dbg_trap = trap_q;
   assign ud_exc   = ud_q;

   // R11
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_q && ud_q));

   // R7
   trap_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> exc_q);

   // R8
   shadow_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ins_shadow && !pend_vld) |=> !trap_q);
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
   import dbg_pkg::*;
#(
   parameter int unsigned AW   = 32,
   parameter int unsigned NCMP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_vld,
   input  logic [AW-1:0]    ins_pc,
   input  logic             ins_rf,
   input  logic             ins_tf,
   input  logic             ins_shadow,
   input  logic             acc_vld,
   input  logic             acc_wr,
   input  logic [AW-1:0]    acc_addr,
   input  logic [1:0]       acc_len,
   input  logic             dr_req,
   input  logic             dr_wr,
   input  logic [2:0]       dr_idx,
   input  logic [31:0]      dr_wdata,
   input  logic             de_mode,
   output logic             dbg_exc,
   output logic             dbg_trap,
   output logic             ud_exc,
   output logic [31:0]      dr_rdata
);
   logic [NCMP-1:0][AW-1:0] cmp_addr;
   logic [REG_W-1:0]        ctrl;
   logic [NCMP-1:0]         x_hits, d_hits, exc_hits;
   logic                    wr_en, rd_en, exc_upd, set_bs, set_bd, clr_gd;
   logic [2:0]              sel;

   for (genvar n = 0; n < NCMP; n++) begin : g_cmp
      dbg_cmp #(.AW(AW)) u_cmp (
         .en       (ctrl[2*n] | ctrl[2*n+1]),
         .kind     (ctrl[16+4*n +: 2]),
         .size     (ctrl[18+4*n +: 2]),
         .base     (cmp_addr[n]),
         .pc       (ins_pc),
         .acc_vld  (acc_vld),
         .acc_wr   (acc_wr),
         .acc_addr (acc_addr),
         .acc_len  (acc_len),
         .x_hit    (x_hits[n]),
         .d_hit    (d_hits[n])
      );
   end

   dbg_seq #(.NCMP(NCMP)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_vld    (ins_vld),
      .ins_rf     (ins_rf),
      .ins_tf     (ins_tf),
      .ins_shadow (ins_shadow),
      .dr_req     (dr_req),
      .dr_wr      (dr_wr),
      .dr_idx     (dr_idx),
      .de_mode    (de_mode),
      .gd_on      (ctrl[CTRL_GD]),
      .x_hits     (x_hits),
      .d_hits     (d_hits),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .sel        (sel),
      .exc_upd    (exc_upd),
      .exc_hits   (exc_hits),
      .set_bs     (set_bs),
      .set_bd     (set_bd),
      .clr_gd     (clr_gd),
      .dbg_exc    (dbg_exc),
      .dbg_trap   (dbg_trap),
      .ud_exc     (ud_exc)
   );

   dbg_regs #(.AW(AW), .NCMP(NCMP)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .sel      (sel),
      .wdata    (dr_wdata),
      .exc_upd  (exc_upd),
      .exc_hits (exc_hits),
      .set_bs   (set_bs),
      .set_bd   (set_bd),
      .clr_gd   (clr_gd),
      .cmp_addr (cmp_addr),
      .ctrl     (ctrl),
      .rdata    (dr_rdata)
   );

   // R3
   xfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_vld && (|x_hits) && !ins_rf) |=> (dbg_exc && !dbg_trap));

   // R10
   ud_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_vld && dr_req && de_mode && dr_idx[2:1] == 2'b10 &&
       !ctrl[CTRL_GD] && !((|x_hits) && !ins_rf)) |=> (ud_exc && !dbg_exc));
endmodule

// File: tb/dbg_bkpt_unit_bench.sv
`timescale 1ns/1ps
module dbg_bkpt_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_vld, ins_rf, ins_tf, ins_shadow;
   logic [31:0] ins_pc;
   logic        acc_vld, acc_wr;
   logic [31:0] acc_addr;
   logic [1:0]  acc_len;
   logic        dr_req, dr_wr;
   logic [2:0]  dr_idx;
   logic [31:0] dr_wdata;
   logic        de_mode = 1'b0;
   logic        dbg_exc, dbg_trap, ud_exc;
   logic [31:0] dr_rdata;

   int    n_run = 0, n_fail = 0;
   bit    finished = 0;
   string cur_tag = "R1";

   always #2 clk = ~clk;

   dbg_bkpt_unit u_dbg_bkpt_unit (
      .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_pc(ins_pc),
      .ins_rf(ins_rf), .ins_tf(ins_tf), .ins_shadow(ins_shadow),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
      .acc_len(acc_len), .dr_req(dr_req), .dr_wr(dr_wr), .dr_idx(dr_idx),
      .dr_wdata(dr_wdata), .de_mode(de_mode), .dbg_exc(dbg_exc),
      .dbg_trap(dbg_trap), .ud_exc(ud_exc), .dr_rdata(dr_rdata)
   );

   // behavioural reference model
   logic [31:0] m_dr [4];
   logic [31:0] m_stat, m_ctrl, exp_rd;
   bit          m_tf, m_pv, m_pbs, exp_exc, exp_trap, exp_ud;
   bit   [3:0]  m_ph, xh, dh, th;
   bit          tb_bs, tf_old, en_n;
   longint      lo, hi, alo, ahi, sz, asz;
   int          rw, ln, ix;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) m_dr[k] = 0;
         m_stat = 32'hFFFF0FF0; m_ctrl = 32'h400; exp_rd = 0;
         m_tf = 0; m_pv = 0; m_pbs = 0; m_ph = 0;
         exp_exc = 0; exp_trap = 0; exp_ud = 0;
      end else begin
         for (int k = 0; k < 4; k++) begin
            en_n = m_ctrl[2*k] | m_ctrl[2*k+1];
            rw   = int'(m_ctrl[16+4*k +: 2]);
            ln   = int'(m_ctrl[18+4*k +: 2]);
            sz   = (ln == 0) ? 1 : (ln == 1) ? 2 : 4;
            lo   = longint'(m_dr[k]) - (longint'(m_dr[k]) % sz);
            hi   = lo + sz - 1;
            asz  = (acc_len == 0) ? 1 : (acc_len == 1) ? 2 : 4;
            alo  = longint'(acc_addr);
            ahi  = alo + asz - 1;
            xh[k] = en_n && rw == 0 && ins_pc == m_dr[k];
            dh[k] = en_n && acc_vld && (rw == 3 || (rw == 1 && acc_wr)) &&
                    alo <= hi && lo <= ahi;
         end
         exp_exc = 0; exp_trap = 0; exp_ud = 0;
         if (ins_vld) begin
            if (!ins_rf && xh != 0) begin
               exp_exc = 1; m_stat[3:0] = xh;
            end else if (dr_req && m_ctrl[13]) begin
               exp_exc = 1; m_stat[3:0] = 0; m_stat[13] = 1; m_ctrl[13] = 0;
            end else if (dr_req && de_mode && (dr_idx == 4 || dr_idx == 5)) begin
               exp_ud = 1;
            end else begin
               ix = int'(dr_idx);
               if (ix == 4) ix = 6;
               if (ix == 5) ix = 7;
               if (dr_req && !dr_wr)
                  exp_rd = (ix < 4) ? m_dr[ix] : (ix == 6) ? m_stat : m_ctrl;
               if (dr_req && dr_wr) begin
                  if (ix < 4) m_dr[ix] = dr_wdata;
                  else if (ix == 6) m_stat = 32'hFFFF0FF0 | (dr_wdata & 32'h600F);
                  else m_ctrl = (dr_wdata & 32'hFFFF23FF) | 32'h400;
               end
               tf_old = m_tf; m_tf = ins_tf;
               if (ins_shadow && !m_pv) begin
                  m_pv = 1; m_ph = dh; m_pbs = tf_old;
               end else begin
                  th = dh | m_ph; tb_bs = tf_old | m_pbs;
                  m_pv = 0; m_ph = 0; m_pbs = 0;
                  if (th != 0 || tb_bs) begin
                     exp_exc = 1; exp_trap = 1; m_stat[3:0] = th;
                     if (tb_bs) m_stat[14] = 1;
                  end
               end
            end
         end
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_run++;
         if (dbg_exc !== exp_exc || dbg_trap !== exp_trap || ud_exc !== exp_ud ||
             dr_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s cycle: got exc=%0b trap=%0b ud=%0b rd=%h exp exc=%0b trap=%0b ud=%0b rd=%h",
                     cur_tag, dbg_exc, dbg_trap, ud_exc, dr_rdata,
                     exp_exc, exp_trap, exp_ud, exp_rd);
         end
      end
   end

   task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic idle_in();
      ins_vld = 0; ins_pc = 32'h8000; ins_rf = 0; ins_tf = 0; ins_shadow = 0;
      acc_vld = 0; acc_wr = 0; acc_addr = 0; acc_len = 0;
      dr_req = 0; dr_wr = 0; dr_idx = 0; dr_wdata = 0;
   endtask

   task automatic op_ins(input logic [31:0] pc, input bit tf, input bit sh, input bit rf);
      @(negedge clk); idle_in();
      ins_vld = 1; ins_pc = pc; ins_tf = tf; ins_shadow = sh; ins_rf = rf;
   endtask

   task automatic op_acc(input logic [31:0] a, input logic [1:0] l, input bit wr,
                         input bit tf, input bit sh);
      @(negedge clk); idle_in();
      ins_vld = 1; ins_tf = tf; ins_shadow = sh;
      acc_vld = 1; acc_addr = a; acc_len = l; acc_wr = wr;
   endtask

   task automatic op_dr(input logic [31:0] pc, input bit wr, input logic [2:0] idx,
                        input logic [31:0] d, input bit tf);
      @(negedge clk); idle_in();
      ins_vld = 1; ins_pc = pc; ins_tf = tf;
      dr_req = 1; dr_wr = wr; dr_idx = idx; dr_wdata = d;
   endtask

   task automatic settle();
      @(negedge clk); idle_in();
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      op_dr(32'h8000, 1, idx, d, 0); settle();
   endtask

   task automatic rd(input logic [2:0] idx, input logic [31:0] e, input string tag);
      op_dr(32'h8000, 0, idx, 0, 0); settle();
      check32(tag, dr_rdata, e);
   endtask

   task automatic outs(input bit e, input bit t, input bit u, input string tag);
      check32(tag, {29'd0, dbg_exc, dbg_trap, ud_exc}, {29'd0, e, t, u});
   endtask

   initial begin
      idle_in();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      cur_tag = "R1";
      outs(0, 0, 0, "R1 outputs after reset");
      rd(6, 32'hFFFF0FF0, "R1 status reset");
      rd(7, 32'h00000400, "R1 control reset");
      // R2 fixed bits
      cur_tag = "R2";
      wr(6, 32'hFFFFFFFF); rd(6, 32'hFFFF6FFF, "R2 status all ones");
      wr(6, 32'h0);        rd(6, 32'hFFFF0FF0, "R2 status cleared");
      wr(7, 32'h0);        rd(7, 32'h00000400, "R2 control bit10");
      // R10 aliases
      cur_tag = "R10";
      wr(4, 32'h0000400F); rd(6, 32'hFFFF4FFF, "R10 idx4 aliases status");
      rd(5, 32'h00000400, "R10 idx5 aliases control");
      de_mode = 1;
      op_dr(32'h8000, 0, 5, 0, 0); settle(); outs(0, 0, 1, "R10 idx5 with extensions");
      op_dr(32'h8000, 1, 4, 0, 0); settle(); outs(0, 0, 1, "R10 idx4 write with extensions");
      de_mode = 0;
      rd(6, 32'hFFFF4FFF, "R10 blocked write left status");
      wr(6, 32'h0);
      // R3 / R4 execute match
      cur_tag = "R3";
      wr(0, 32'h1000); wr(7, 32'h00000401);
      op_ins(32'h1000, 0, 0, 0); settle(); outs(1, 0, 0, "R3 execute fault");
      rd(6, 32'hFFFF0FF1, "R3 status B0");
      op_ins(32'h1004, 0, 0, 0); settle(); outs(0, 0, 0, "R3 other pc");
      cur_tag = "R4";
      op_ins(32'h1000, 0, 0, 1); settle(); outs(0, 0, 0, "R4 resume flag");
      // R5 data matches
      cur_tag = "R5";
      wr(1, 32'h2002); wr(7, 32'h00D00409);
      op_acc(32'h2003, 2'b00, 1, 0, 0); settle(); outs(1, 1, 0, "R5 write in range");
      rd(6, 32'hFFFF0FF2, "R5 status B1");
      op_acc(32'h2000, 2'b00, 0, 0, 0); settle(); outs(0, 0, 0, "R5 read on write-only");
      op_acc(32'h1FFE, 2'b01, 1, 0, 0); settle(); outs(0, 0, 0, "R5 below range");
      op_acc(32'h1FFF, 2'b01, 1, 0, 0); settle(); outs(1, 1, 0, "R5 straddle low edge");
      op_acc(32'h2004, 2'b11, 1, 0, 0); settle(); outs(0, 0, 0, "R5 above range");
      wr(2, 32'h3003); wr(7, 32'h05000410);
      op_acc(32'h3001, 2'b00, 1, 0, 0); settle(); outs(0, 0, 0, "R5 two-byte miss");
      op_acc(32'h3002, 2'b00, 1, 0, 0); settle(); outs(1, 1, 0, "R5 two-byte aligned hit");
      wr(7, 32'h06000410);
      op_acc(32'h3002, 2'b00, 1, 0, 0); settle(); outs(0, 0, 0, "R5 io type never");
      // R6 sticky vs rewritten
      cur_tag = "R6";
      wr(7, 32'h00F00409); wr(6, 32'h00004000);
      op_acc(32'h2001, 2'b00, 0, 0, 0); settle(); outs(1, 1, 0, "R6 read-write hit");
      rd(6, 32'hFFFF4FF2, "R6 BS kept, B1 set");
      op_ins(32'h1000, 0, 0, 0); settle();
      rd(6, 32'hFFFF4FF1, "R6 B1 rewritten by B0");
      // R7 single step
      cur_tag = "R7";
      wr(7, 32'h400); wr(6, 32'h0);
      op_ins(32'h100, 1, 0, 0); settle(); outs(0, 0, 0, "R7 setter no trap");
      op_ins(32'h104, 1, 0, 0); settle(); outs(1, 1, 0, "R7 first step");
      op_ins(32'h108, 0, 0, 0); settle(); outs(1, 1, 0, "R7 clearer traps");
      op_ins(32'h10C, 0, 0, 0); settle(); outs(0, 0, 0, "R7 disarmed");
      rd(6, 32'hFFFF4FF0, "R7 BS set");
      // R8 shadow
      cur_tag = "R8";
      wr(6, 32'h0);
      op_ins(32'h200, 1, 0, 0); settle();
      op_ins(32'h204, 1, 1, 0); settle(); outs(0, 0, 0, "R8 step held by shadow");
      op_ins(32'h208, 0, 0, 0); settle(); outs(1, 1, 0, "R8 merged step");
      op_ins(32'h20C, 0, 0, 0); settle(); outs(0, 0, 0, "R8 nothing left");
      wr(1, 32'h2000); wr(7, 32'h00D00408);
      op_acc(32'h2000, 2'b00, 1, 0, 1); settle(); outs(0, 0, 0, "R8 data held");
      op_ins(32'h210, 0, 0, 0); settle(); outs(1, 1, 0, "R8 data delivered");
      rd(6, 32'hFFFF4FF2, "R8 status after deferral");
      op_acc(32'h2000, 2'b00, 1, 0, 1); settle(); outs(0, 0, 0, "R8 held again");
      op_ins(32'h214, 0, 1, 0); settle(); outs(1, 1, 0, "R8 shadow does not chain");
      // R12 coinciding conditions, R13 ordering
      cur_tag = "R12";
      wr(6, 32'h0);
      op_ins(32'h300, 1, 0, 0); settle();
      op_acc(32'h2002, 2'b00, 1, 0, 0); settle(); outs(1, 1, 0, "R12 single request");
      settle(); outs(0, 0, 0, "R12 no second request");
      rd(6, 32'hFFFF4FF2, "R12 BS and B1 together");
      cur_tag = "R13";
      wr(7, 32'h400); wr(6, 32'h0);
      op_ins(32'h400, 1, 0, 0); settle();
      op_dr(32'h8000, 0, 6, 0, 0); settle();
      outs(1, 1, 0, "R13 read instr traps");
      check32("R13 read sees old status", dr_rdata, 32'hFFFF0FF0);
      rd(6, 32'hFFFF4FF0, "R13 status updated after");
      op_ins(32'h404, 1, 0, 0); settle();
      op_dr(32'h8000, 1, 6, 32'h0, 0); settle();
      rd(6, 32'hFFFF4FF0, "R13 trap bits over write");
      // R9 general detect
      cur_tag = "R9";
      wr(6, 32'h0); wr(7, 32'h2400);
      op_ins(32'h500, 0, 1, 0); settle();
      op_dr(32'h8000, 0, 0, 0, 0); settle(); outs(1, 0, 0, "R9 fault despite shadow");
      rd(7, 32'h00000400, "R9 GD cleared");
      rd(6, 32'hFFFF2FF0, "R9 BD set");
      // R11 priority
      cur_tag = "R11";
      wr(0, 32'h1000); wr(7, 32'h2401);
      op_dr(32'h1000, 0, 7, 0, 0); settle(); outs(1, 0, 0, "R11 execute before GD");
      de_mode = 1;
      op_dr(32'h9000, 0, 4, 0, 0); settle(); outs(1, 0, 0, "R11 GD before UD");
      de_mode = 0;
      rd(7, 32'h00000401, "R11 GD cleared by second");
      rd(6, 32'hFFFF2FF0, "R11 status after GD");
      repeat (2) settle();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got hung exp finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule